// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits between a simple memory-request port and the command pins of a four-bank SDRAM. A host presents one request at a time: a bank, a row, a column, a read/write direction and an auto-precharge flag. It holds the request until the block acknowledges it. The sequencer keeps, for each bank, whether a row is open and which row it is. It then emits the shortest legal command sequence. A column access to an open matching row goes out at once. A closed bank is first activated. A bank holding a different row is first precharged, then activated, then accessed.

After reset the block precharges every bank and loads the mode register from its parameters, which set the burst length and the CAS latency. A free-running timer raises a refresh demand every `REF_CYCLES` clocks. A pending refresh wins over any waiting request. The block closes all open banks with one precharge-all command, then issues Auto Refresh. Every gap between commands is a parameter counted in clock cycles. Data transfer and power-down are outside this block.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Reset drives chip select high with `req_ack` low. The first command after reset is Precharge with address bit 10 high. `T_RP` cycles later comes Mode Register Set with bank 0, address bits [2:0] = log2(burst length), bit 3 = 0 and bits [6:4] = 3'b010 for CAS 2 or 3'b110 for CAS 2.5. No request is acknowledged before that Mode Register Set.
- R2: Commands use {cs_n, ras_n, cas_n, we_n}: NOP 0111, Activate 0011, Read 0101, Write 0100, Precharge 0010, Auto Refresh 0001, Mode Register Set 0000. Idle cycles carry NOP.
- R3: A request to a bank with no open row first issues Activate, with the bank on `cmd_ba` and the row on `cmd_addr`. The Read or Write follows exactly `T_RCD` cycles later.
- R4: A request whose row is already open in its bank issues the column command directly, without Activate. `cmd_addr[9:0]` carries column bits [9:0], and bit 11 carries column bit 10 when `COL_W` is 11. `cmd_addr[10]` carries the auto-precharge flag. The command is Write when `req_write` is 1, otherwise Read.
- R5: A request to a bank holding a different row issues Precharge with `cmd_addr[10]` low on that bank. Activate follows `T_RP` cycles later, and the column command `T_RCD` cycles after the Activate.
- R6: `req_ack` is high for exactly one cycle, in the same cycle as the request's Read or Write command on the pins.
- R7: A column command with auto-precharge closes only its own bank. The next access to that bank begins with Activate, not Precharge, at least `BURST_LEN/2 + T_RP` cycles after the column command.
- R8: Every `REF_CYCLES` cycles a refresh becomes pending and takes priority over any waiting request. If any bank is open, Precharge with `cmd_addr[10]` high comes first, and Auto Refresh follows `T_RP` cycles later. Auto Refresh is only issued with every bank closed.
- R9: Successive column commands are at least `BURST_LEN/2` cycles apart. No command follows Auto Refresh within `T_RFC` cycles. With all banks closed, successive Auto Refresh commands are exactly `REF_CYCLES` cycles apart.
- R10: Each bank keeps its own open row. Opening or closing one bank leaves the others' rows open, so a later access to them is a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_autopre | input | 1 | Close the row after this burst |
| req_ack | output | 1 | One-cycle pulse with the column command |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ROW_W | Row, column or mode word; bit 10 selects all-bank precharge or auto-precharge |

## Verification
The assertions take for granted that the host keeps `req_valid` and the request fields steady until it sees `req_ack`, and that it drops `req_valid` before the next rising edge. Otherwise the single-cycle acknowledge and the open/closed checks on the bank table could fire on a stale request. The bench drives every request on the falling edge. It clears `req_valid` on the same falling edge that first shows `req_ack` high, and it never changes fields while a request waits. The one deliberate collision is a request raised just as a refresh drain starts, which shows that the refresh keeps priority.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    C_MRS  = 4'b0000,
    C_REF  = 4'b0001,
    C_PRE  = 4'b0010,
    C_ACT  = 4'b0011,
    C_WR   = 4'b0100,
    C_RD   = 4'b0101,
    C_NOP  = 4'b0111,
    C_DSEL = 4'b1111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_MODE,
    ST_RUN
  } seq_st_e;
endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          idle
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R9: a new gap is only started once the previous one has run out
  assert_gap_reload_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));
endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int REF_CYCLES = 975
) (
  input  logic clk,
  input  logic rst,
  input  logic served,
  output logic pending
);
  localparam int RW = $clog2(REF_CYCLES + 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= RW'(REF_CYCLES - 1);
      pending <= 1'b0;
    end else begin
      if (cnt == '0) cnt <= RW'(REF_CYCLES - 1);
      else           cnt <= cnt - 1'b1;
      if (cnt == '0)   pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end

  // R8: a refresh is only issued against an outstanding demand
  assert_serve_pending_R8: assert property (@(posedge clk) disable iff (rst)
    served |-> pending);
endmodule

// File: rtl/seq_bank_rows.sv
module seq_bank_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_en,
  input  logic [BANK_W-1:0]    act_bank,
  input  logic [ROW_W-1:0]     act_row,
  input  logic                 pre_one,
  input  logic [BANK_W-1:0]    pre_bank,
  input  logic                 pre_all,
  output logic [(1<<BANK_W)-1:0] open_vec,
  output logic [ROW_W-1:0]     row_q [1<<BANK_W]
);
  localparam int BANKS = 1 << BANK_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (pre_all || (pre_one && pre_bank == BANK_W'(b))) begin
        open_r <= 1'b0;
      end else if (act_en && act_bank == BANK_W'(b)) begin
        open_r <= 1'b1;
        row_r  <= act_row;
      end
    end
    assign open_vec[b] = open_r;
    assign row_q[b]    = row_r;
  end

  // R3: Activate is never sent to a bank that already holds a row
  assert_act_closed_R3: assert property (@(posedge clk) disable iff (rst)
    act_en |-> !open_vec[act_bank]);
  // R5: a single-bank close only targets a bank that is open
  assert_close_open_R5: assert property (@(posedge clk) disable iff (rst)
    pre_one |-> open_vec[pre_bank]);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int BURST_LEN  = 4,
  parameter int CAS_HALF   = 5,
  parameter int T_RP       = 3,
  parameter int T_RCD      = 3,
  parameter int T_RFC      = 9,
  parameter int T_MRD      = 2,
  parameter int REF_CYCLES = 975
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic              req_ack,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_addr
);
  localparam int BANKS   = 1 << BANK_W;
  localparam int T_COL   = BURST_LEN / 2;
  localparam int T_APRE  = T_COL + T_RP;
  localparam int GAP_MAX = T_RFC + T_APRE + T_RCD + T_MRD;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam logic [2:0] BL_CODE  = 3'($clog2(BURST_LEN));
  localparam logic [2:0] CAS_CODE = (CAS_HALF == 5) ? 3'b110 : 3'b010;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({CAS_CODE, 1'b0, BL_CODE});

  seq_st_e st, st_n;
  cmd_e    cmd_q, n_cmd;
  logic [BANK_W-1:0] n_ba;
  logic [ROW_W-1:0]  n_addr, col_addr;
  logic              n_ack;
  logic              gap_idle, gap_load;
  logic [GAP_W-1:0]  gap_val;
  logic              act_en, pre_one, pre_all;
  logic              ref_pending, ref_served;
  logic [BANKS-1:0]  open_vec;
  logic [ROW_W-1:0]  row_q [BANKS];
  logic              col_hi, hit;

  seq_gap_timer #(.CW(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .idle(gap_idle)
  );

  seq_refresh_timer #(.REF_CYCLES(REF_CYCLES)) u_ref (
    .clk(clk), .rst(rst), .served(ref_served), .pending(ref_pending)
  );

  seq_bank_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst),
    .act_en(act_en), .act_bank(req_bank), .act_row(req_row),
    .pre_one(pre_one), .pre_bank(req_bank), .pre_all(pre_all),
    .open_vec(open_vec), .row_q(row_q)
  );

  if (COL_W > 10) begin : g_wide_col
    assign col_hi = req_col[COL_W-1];
  end else begin : g_narrow_col
    assign col_hi = 1'b0;
  end

  always_comb begin
    col_addr       = '0;
    col_addr[9:0]  = req_col[9:0];
    col_addr[10]   = req_autopre;
    col_addr[11]   = col_hi;
  end

  assign hit = open_vec[req_bank] && (row_q[req_bank] == req_row);

  always_comb begin
    n_cmd      = C_NOP;
    n_ba       = '0;
    n_addr     = '0;
    n_ack      = 1'b0;
    gap_load   = 1'b0;
    gap_val    = '0;
    act_en     = 1'b0;
    pre_one    = 1'b0;
    pre_all    = 1'b0;
    ref_served = 1'b0;
    st_n       = st;
    if (gap_idle) begin
      case (st)
        ST_BOOT: begin
          n_cmd      = C_PRE;
          n_addr[10] = 1'b1;
          pre_all    = 1'b1;
          gap_load   = 1'b1;
          gap_val    = GAP_W'(T_RP - 1);
          st_n       = ST_MODE;
        end
        ST_MODE: begin
          n_cmd    = C_MRS;
          n_addr   = MODE_WORD;
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_MRD - 1);
          st_n     = ST_RUN;
        end
        default: begin
          if (ref_pending) begin
            gap_load = 1'b1;
            if (|open_vec) begin
              n_cmd      = C_PRE;
              n_addr[10] = 1'b1;
              pre_all    = 1'b1;
              gap_val    = GAP_W'(T_RP - 1);
            end else begin
              n_cmd      = C_REF;
              ref_served = 1'b1;
              gap_val    = GAP_W'(T_RFC - 1);
            end
          end else if (req_valid) begin
            gap_load = 1'b1;
            n_ba     = req_bank;
            if (!open_vec[req_bank]) begin
              n_cmd   = C_ACT;
              n_addr  = req_row;
              act_en  = 1'b1;
              gap_val = GAP_W'(T_RCD - 1);
            end else if (hit) begin
              n_cmd   = req_write ? C_WR : C_RD;
              n_addr  = col_addr;
              n_ack   = 1'b1;
              pre_one = req_autopre;
              gap_val = req_autopre ? GAP_W'(T_APRE - 1) : GAP_W'(T_COL - 1);
            end else begin
              n_cmd   = C_PRE;
              pre_one = 1'b1;
              gap_val = GAP_W'(T_RP - 1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_BOOT;
      cmd_q    <= C_DSEL;
      cmd_ba   <= '0;
      cmd_addr <= '0;
      req_ack  <= 1'b0;
    end else begin
      st       <= st_n;
      cmd_q    <= n_cmd;
      cmd_ba   <= n_ba;
      cmd_addr <= n_addr;
      req_ack  <= n_ack;
    end
  end

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

  // R8: Auto Refresh only leaves with every bank closed
  assert_ref_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == C_REF) |-> (open_vec == '0));
  // R6: acknowledge is a single-cycle pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
  // R6: acknowledge coincides with a column command
  assert_ack_col_R6: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (cmd_q == C_RD || cmd_q == C_WR));
  // R1: no acknowledge while the boot sequence is still running
  assert_ack_after_boot_R1: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (st == ST_RUN));
endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int ROW_W = 13, COL_W = 10, BANK_W = 2;
  localparam int BL = 4, T_RP = 3, T_RCD = 3, T_RFC = 9, T_MRD = 2, REFC = 1500;
  localparam int T_COL = BL / 2;
  localparam logic [3:0] K_MRS = 4'b0000, K_REF = 4'b0001, K_PRE = 4'b0010,
                         K_ACT = 4'b0011, K_WR = 4'b0100, K_RD = 4'b0101;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic req_ack, cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] cmd_ba;
  logic [ROW_W-1:0]  cmd_addr;

  int n_tests = 0, n_fail = 0, cyc = 0, ack_cyc = -1, n_log = 0;
  logic [3:0]       lg_cmd  [128];
  logic [1:0]       lg_ba   [128];
  logic [ROW_W-1:0] lg_addr [128];
  int               lg_cyc  [128];

  always #4 clk = ~clk;

  sdram_cmd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BL),
    .CAS_HALF(5), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .REF_CYCLES(REFC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_ack(req_ack), .cmd_cs_n(cs_n),
    .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr));

  // command monitor, sampling shortly after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (!cs_n && {ras_n, cas_n, we_n} != 3'b111 && n_log < 128) begin
      lg_cmd[n_log]  = {cs_n, ras_n, cas_n, we_n};
      lg_ba[n_log]   = cmd_ba;
      lg_addr[n_log] = cmd_addr;
      lg_cyc[n_log]  = cyc;
      n_log++;
    end
    if (req_ack) ack_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_entry(input int i, input logic [3:0] c, input int ba,
                           input int addr, input string req);
    chk(i < n_log && lg_cmd[i] == c, req, (i < n_log) ? int'(lg_cmd[i]) : -1, int'(c));
    if (i < n_log && ba >= 0)   chk(int'(lg_ba[i]) == ba, req, int'(lg_ba[i]), ba);
    if (i < n_log && addr >= 0) chk(int'(lg_addr[i]) == addr, req, int'(lg_addr[i]), addr);
  endtask

  function automatic int col_word(input int c, input bit ap);
    return c | (int'(ap) << 10);
  endfunction

  // drive a request on a falling edge and hold it until acknowledged
  task automatic issue(input bit w, input int b, input int r, input int c, input bit ap,
                       input bit raise_now, output int start);
    int k;
    if (!raise_now) @(negedge clk);
    start = n_log;
    req_write = w; req_bank = BANK_W'(b); req_row = ROW_W'(r);
    req_col = COL_W'(c); req_autopre = ap; req_valid = 1'b1;
    for (k = 0; k < 400; k++) begin
      @(negedge clk);
      if (req_ack) break;
    end
    req_valid = 1'b0;
    if (k == 400) chk(0, "ack timeout", k, 0);
  endtask

  task automatic wait_cmd(input logic [3:0] c, input int from, output int idx);
    idx = -1;
    for (int k = 0; k < 3000 && idx < 0; k++) begin
      @(negedge clk);
      for (int i = from; i < n_log; i++)
        if (idx < 0 && lg_cmd[i] == c) idx = i;
    end
    if (idx < 0) chk(0, "command wait timeout", -1, int'(c));
  endtask

  task automatic t_reset_boot();
    int s;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n", int'(cs_n), 1);
    chk(req_ack == 1'b0, "R1 reset ack", int'(req_ack), 0);
    rst = 1'b0;
    issue(0, 0, 5, 8, 0, 1, s);
    chk_entry(0, K_PRE, -1, -1, "R1 first precharge");
    chk(lg_addr[0][10] == 1'b1, "R1 precharge-all A10", int'(lg_addr[0][10]), 1);
    chk_entry(1, K_MRS, 0, 'h062, "R1 mode word");
    chk(lg_cyc[1] - lg_cyc[0] == T_RP, "R1 mode gap", lg_cyc[1] - lg_cyc[0], T_RP);
    chk_entry(2, K_ACT, 0, 5, "R3 activate closed bank");
    chk(lg_cyc[2] - lg_cyc[1] == T_MRD, "R1 ack after mode set", lg_cyc[2] - lg_cyc[1], T_MRD);
    chk_entry(3, K_RD, 0, 8, "R3 read after activate");
    chk(lg_cyc[3] - lg_cyc[2] == T_RCD, "R3 tRCD gap", lg_cyc[3] - lg_cyc[2], T_RCD);
    chk(ack_cyc == lg_cyc[3], "R6 ack with column", ack_cyc, lg_cyc[3]);
  endtask

  task automatic t_row_hit();
    int s, prev;
    prev = lg_cyc[n_log-1];
    issue(0, 0, 5, 'h3FF, 0, 0, s);
    chk(n_log == s + 1, "R4 hit issues one command", n_log - s, 1);
    chk_entry(s, K_RD, 0, 'h3FF, "R4 read hit");
    chk(lg_cyc[s] - prev >= T_COL, "R9 column spacing", lg_cyc[s] - prev, T_COL);
    prev = lg_cyc[s];
    issue(1, 0, 5, 'h155, 0, 0, s);
    chk_entry(s, K_WR, 0, 'h155, "R4 write hit");
    chk(lg_cyc[s] - prev >= T_COL, "R9 column spacing write", lg_cyc[s] - prev, T_COL);
    @(negedge clk);
    chk(req_ack == 1'b0, "R6 ack single cycle", int'(req_ack), 0);
  endtask

  task automatic t_row_miss();
    int s;
    issue(0, 0, 9, 4, 0, 0, s);
    chk_entry(s, K_PRE, 0, 0, "R5 single-bank precharge");
    chk_entry(s + 1, K_ACT, 0, 9, "R5 activate new row");
    chk(lg_cyc[s+1] - lg_cyc[s] == T_RP, "R5 tRP gap", lg_cyc[s+1] - lg_cyc[s], T_RP);
    chk_entry(s + 2, K_RD, 0, 4, "R5 read after reopen");
    chk(lg_cyc[s+2] - lg_cyc[s+1] == T_RCD, "R5 tRCD gap", lg_cyc[s+2] - lg_cyc[s+1], T_RCD);
  endtask

  task automatic t_independent_banks();
    int s;
    issue(0, 1, 3, 1, 0, 0, s);
    chk_entry(s, K_ACT, 1, 3, "R10 open second bank");
    issue(0, 0, 9, 2, 0, 0, s);
    chk(n_log == s + 1, "R10 first bank still open", n_log - s, 1);
    chk_entry(s, K_RD, 0, 2, "R10 hit on untouched bank");
  endtask

  task automatic t_auto_precharge();
    int s, colc;
    issue(1, 2, 7, 'h10, 1, 0, s);
    chk_entry(s, K_ACT, 2, 7, "R7 activate");
    chk_entry(s + 1, K_WR, 2, col_word('h10, 1), "R4 write with auto-precharge flag");
    colc = lg_cyc[s+1];
    issue(0, 2, 7, 'h11, 0, 0, s);
    chk_entry(s, K_ACT, 2, 7, "R7 reopen without precharge");
    chk(lg_cyc[s] - colc >= T_COL + T_RP, "R7 auto-precharge hold-off", lg_cyc[s] - colc, T_COL + T_RP);
    issue(0, 1, 3, 6, 0, 0, s);
    chk(n_log == s + 1, "R7 other bank untouched", n_log - s, 1);
    chk_entry(s, K_RD, 1, 6, "R7 other bank hit");
  endtask

  task automatic t_refresh();
    int p, s, r1, r2;
    wait_cmd(K_PRE, n_log, p);
    if (p < 0) return;
    chk(lg_addr[p][10] == 1'b1, "R8 drain uses precharge-all", int'(lg_addr[p][10]), 1);
    issue(0, 3, 2, 0, 0, 1, s);
    chk_entry(p + 1, K_REF, -1, -1, "R8 refresh before waiting request");
    chk(lg_cyc[p+1] - lg_cyc[p] == T_RP, "R8 refresh after tRP", lg_cyc[p+1] - lg_cyc[p], T_RP);
    chk_entry(p + 2, K_ACT, 3, 2, "R8 request served after refresh");
    chk(lg_cyc[p+2] - lg_cyc[p+1] >= T_RFC, "R9 tRFC gap", lg_cyc[p+2] - lg_cyc[p+1], T_RFC);
    wait_cmd(K_REF, p + 2, r1);
    if (r1 < 0) return;
    wait_cmd(K_REF, r1 + 1, r1);
    if (r1 < 0) return;
    wait_cmd(K_REF, r1 + 1, r2);
    if (r2 < 0) return;
    chk(lg_cyc[r2] - lg_cyc[r1] == REFC, "R9 refresh period", lg_cyc[r2] - lg_cyc[r1], REFC);
    chk(lg_cmd[r2-1] == K_REF, "R8 no precharge when idle", int'(lg_cmd[r2-1]), int'(K_REF));
  endtask

  initial begin
    #(8 * 100000);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_boot();
    t_row_hit();
    t_row_miss();
    t_independent_banks();
    t_auto_precharge();
    t_refresh();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule